// File: doc/BRIEF.md
# Paired-Core Hub Slot Arbiter

This block decides, once per clock, which of sixteen cores owns the shared hub slot. A free-running slot counter steps through the sixteen core numbers. The cores form eight fixed pairs: a lower core `p` and an upper core `p+8`. Each pair has its own sharing mode. In the default mode every core simply owns its own slot, so each core gets one slot in sixteen. The other modes let the lower core take its partner's slot outright, give the lower core first claim on both slots of the pair, or let each core fall back to its partner's slot when that slot goes unused. The decision of which core is primary is made by gating the top bit of the counter.

A slot that nobody in the pair claims can be handed to a moocher. There is either one moocher for every free slot, or two moochers that split the free slots by slot parity. A core whose running flag is low is never granted. The grant is a one-hot vector together with the binary index of the granted core. Configuration inputs are sampled only at the end of a rotation, so a whole rotation always runs under a single configuration.

Top module: `hub_pair_arbiter`

## Requirements
- R1: During reset and after it, `grant` is all zero and `grant_id` is 0. The first rotation after reset runs with every pair unpaired and mooching off, whatever the configuration inputs hold.
- R2: In unpaired mode (pair mode code 00), slot `s` is granted only to core `s`, and only when that core is eligible.
- R3: In lend mode (code 01), both slots of the pair go to the lower core, because bit 3 of the slot number is forced to 0. The upper core is never granted through the pair.
- R4: In lead mode (code 10), the lower core has first claim on both slots of the pair. The upper core gets either slot when the lower core is not eligible.
- R5: In own-first mode (code 11), each core has first claim on its own slot. An unclaimed slot goes to the partner if the partner is eligible.
- R6: A grant for slot `s` only ever goes to core `s mod 8`, core `s mod 8 + 8`, or the moocher for that slot. The mode of one pair never changes the grants made in any other pair's slots.
- R7: With mooch select 01, core `mooch_even_id` receives every slot that the pair rules leave unclaimed.
- R8: With mooch select 10, unclaimed even slots go to `mooch_even_id` and unclaimed odd slots go to `mooch_odd_id`. Select codes 00 and 11 disable mooching.
- R9: A core is eligible only when both its `req` bit and its `run` bit are high. A core that is not running is never granted.
- R10: `pair_mode`, `mooch_sel` and both moocher ids are sampled in the cycle that slot 15 is decoded, and they apply from the next slot 0. Slot `s` is decoded one clock before its grant is registered. The requests used for slot `s` are those present at the clock edge that registers the grant.
- R11: When no primary core, partner or moocher is eligible for a slot, `grant` is all zero and `grant_id` is 0.
- R12: `grant` has at most one bit set. When a bit is set, `grant_id` is that bit's index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 16 | Per-core hub request |
| run | input | 16 | Per-core running flag |
| pair_mode | input | 16 | Two bits per pair; pair p at bits 2p+1:2p (00 unpaired, 01 lend, 10 lead, 11 own-first) |
| mooch_sel | input | 2 | 00 off, 01 single moocher, 10 parity split, 11 off |
| mooch_even_id | input | 4 | Single moocher, or the moocher for even slots |
| mooch_odd_id | input | 4 | Moocher for odd slots in split mode |
| grant | output | 16 | One-hot grant for the current slot |
| grant_id | output | 4 | Index of the granted core, 0 when idle |

## Verification
The hardest cases to reach are slots where one decision falls through the whole chain. In these, the primary core is absent, the partner is absent or not running, and the moocher named for that slot's parity decides the grant. The same configuration must also have been latched at the right rotation boundary. The stimulus produces these cases in two ways. It draws random per-pair modes, requests and running flags inside one rotation. It also changes the configuration at instants that are not aligned to a rotation. A behavioural model that tracks the rotation phase on its own predicts every grant.

// File: rtl/hub_pair_pkg.sv
// Shared encodings for the paired-core hub slot arbiter.
// Assumes the two-bit mode and mooch-select field widths used at the top.
package hub_pair_pkg;

    typedef enum logic [1:0] {
        PM_SOLO     = 2'b00,  // each core owns only its own slot
        PM_LEND     = 2'b01,  // lower core takes both slots, upper gets none
        PM_LEAD     = 2'b10,  // lower core first on both, upper as fallback
        PM_OWNFIRST = 2'b11   // each first on own slot, partner as fallback
    } pair_mode_e;

    typedef enum logic [1:0] {
        MO_OFF   = 2'b00,
        MO_ALL   = 2'b01,     // one moocher for every free slot
        MO_SPLIT = 2'b10,     // even/odd slots go to two moochers
        MO_NONE  = 2'b11      // reserved, behaves as off
    } mooch_sel_e;

endpackage

// File: rtl/hub_slot_sequencer.sv
// Slot counter and rotation-aligned configuration latch.
// Assumes the core count is a power of two, so the counter wraps by itself.
// Configuration is captured when the last slot is being decoded and holds
// for one whole rotation.
module hub_slot_sequencer #(
    parameter int NUM_PAIRS = 8,
    parameter int ID_W      = $clog2(2 * NUM_PAIRS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [2*NUM_PAIRS-1:0] cfg_mode,
    input  logic [1:0]             cfg_mooch,
    input  logic [ID_W-1:0]        cfg_even_id,
    input  logic [ID_W-1:0]        cfg_odd_id,
    output logic [ID_W-1:0]        slot_cnt,
    output logic [2*NUM_PAIRS-1:0] act_mode,
    output logic [1:0]             act_mooch,
    output logic [ID_W-1:0]        act_even_id,
    output logic [ID_W-1:0]        act_odd_id
);
    localparam logic [ID_W-1:0] LAST_SLOT = ID_W'(2 * NUM_PAIRS - 1);

    // Advance the slot number by one every clock.
    always_ff @(posedge clk) begin
        if (!rst_n) slot_cnt <= '0;
        else        slot_cnt <= slot_cnt + 1'b1;
    end

    // Capture the configuration only at the rotation boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_mode    <= '0;
            act_mooch   <= 2'b00;
            act_even_id <= '0;
            act_odd_id  <= '0;
        end else if (slot_cnt == LAST_SLOT) begin
            act_mode    <= cfg_mode;
            act_mooch   <= cfg_mooch;
            act_even_id <= cfg_even_id;
            act_odd_id  <= cfg_odd_id;
        end
    end

    // R10: configuration only moves at the end of a rotation
    p_cfg_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_cnt != LAST_SLOT) |=> ($stable(act_mode) && $stable(act_mooch)
                                     && $stable(act_even_id) && $stable(act_odd_id)));

endmodule

// File: rtl/hub_pair_decode.sv
// Decode stage: one clock ahead of the grant, turns the slot number into a
// primary core (top bit gated for donating upper cores), an optional partner
// fallback and an optional moocher. Assumes the pair count is a power of two.
module hub_pair_decode
    import hub_pair_pkg::*;
#(
    parameter int NUM_PAIRS = 8,
    parameter int ID_W      = $clog2(2 * NUM_PAIRS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [ID_W-1:0]        slot_cnt,
    input  logic [2*NUM_PAIRS-1:0] act_mode,
    input  logic [1:0]             act_mooch,
    input  logic [ID_W-1:0]        act_even_id,
    input  logic [ID_W-1:0]        act_odd_id,
    output logic                   s1_vld,
    output logic [ID_W-2:0]        s1_pair,
    output logic [1:0]             s1_mode,
    output logic [ID_W-1:0]        s1_prim,
    output logic                   s1_sec_vld,
    output logic [ID_W-1:0]        s1_sec,
    output logic                   s1_mooch_vld,
    output logic [ID_W-1:0]        s1_mooch_id
);
    localparam int PW = ID_W - 1;

    logic [NUM_PAIRS-1:0] donate;
    logic [PW-1:0]        pair_idx;
    logic [1:0]           mode_now;
    logic [ID_W-1:0]      prim_d;
    logic                 sec_vld_d;
    logic [ID_W-1:0]      sec_d;
    logic                 mooch_vld_d;
    logic [ID_W-1:0]      mooch_id_d;

    // Per pair: does the upper core hand its slot to the lower one.
    genvar g;
    generate
        for (g = 0; g < NUM_PAIRS; g++) begin : g_donate
            assign donate[g] = (act_mode[2*g +: 2] == PM_LEND) ||
                               (act_mode[2*g +: 2] == PM_LEAD);
        end
    endgenerate

    assign pair_idx = slot_cnt[PW-1:0];
    assign mode_now = act_mode[{pair_idx, 1'b0} +: 2];

    // Primary via top-bit gating; fallback partner chosen by mode.
    always_comb begin
        prim_d    = {slot_cnt[ID_W-1] & ~donate[pair_idx], pair_idx};
        sec_vld_d = 1'b0;
        sec_d     = '0;
        case (mode_now)
            PM_LEAD: begin
                sec_vld_d = 1'b1;
                sec_d     = {1'b1, pair_idx};
            end
            PM_OWNFIRST: begin
                sec_vld_d = 1'b1;
                sec_d     = {~slot_cnt[ID_W-1], pair_idx};
            end
            default: ;
        endcase
    end

    // Moocher for this slot from the select code and the slot parity.
    always_comb begin
        mooch_vld_d = 1'b0;
        mooch_id_d  = '0;
        case (act_mooch)
            MO_ALL: begin
                mooch_vld_d = 1'b1;
                mooch_id_d  = act_even_id;
            end
            MO_SPLIT: begin
                mooch_vld_d = 1'b1;
                mooch_id_d  = slot_cnt[0] ? act_odd_id : act_even_id;
            end
            default: ;
        endcase
    end

    // Register the decoded slot for the grant stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_vld       <= 1'b0;
            s1_pair      <= '0;
            s1_mode      <= 2'b00;
            s1_prim      <= '0;
            s1_sec_vld   <= 1'b0;
            s1_sec       <= '0;
            s1_mooch_vld <= 1'b0;
            s1_mooch_id  <= '0;
        end else begin
            s1_vld       <= 1'b1;
            s1_pair      <= pair_idx;
            s1_mode      <= mode_now;
            s1_prim      <= prim_d;
            s1_sec_vld   <= sec_vld_d;
            s1_sec       <= sec_d;
            s1_mooch_vld <= mooch_vld_d;
            s1_mooch_id  <= mooch_id_d;
        end
    end

    // R6: primary and partner always lie inside the slot's own pair
    p_in_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
        s1_vld |-> (s1_prim[PW-1:0] == s1_pair) &&
                   (!s1_sec_vld || s1_sec[PW-1:0] == s1_pair));

endmodule

// File: rtl/hub_grant_resolve.sv
// Grant stage: owner first, then partner, then moocher, else idle; result
// registered as a one-hot vector plus index. Eligibility is req AND run.
module hub_grant_resolve
    import hub_pair_pkg::*;
#(
    parameter int NUM_PAIRS = 8,
    parameter int ID_W      = $clog2(2 * NUM_PAIRS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [2*NUM_PAIRS-1:0] elig,
    input  logic                   s1_vld,
    input  logic [ID_W-2:0]        s1_pair,
    input  logic [1:0]             s1_mode,
    input  logic [ID_W-1:0]        s1_prim,
    input  logic                   s1_sec_vld,
    input  logic [ID_W-1:0]        s1_sec,
    input  logic                   s1_mooch_vld,
    input  logic [ID_W-1:0]        s1_mooch_id,
    output logic [2*NUM_PAIRS-1:0] grant,
    output logic [ID_W-1:0]        grant_id
);
    localparam int NC = 2 * NUM_PAIRS;
    localparam int PW = ID_W - 1;

    logic                 hit;
    logic [ID_W-1:0]      pick;
    logic [NC-1:0]        grant_d;

    // Walk the claim order for the decoded slot.
    always_comb begin
        hit  = 1'b0;
        pick = '0;
        if (s1_vld) begin
            if (elig[s1_prim]) begin
                hit  = 1'b1;
                pick = s1_prim;
            end else if (s1_sec_vld && elig[s1_sec]) begin
                hit  = 1'b1;
                pick = s1_sec;
            end else if (s1_mooch_vld && elig[s1_mooch_id]) begin
                hit  = 1'b1;
                pick = s1_mooch_id;
            end
        end
    end

    genvar i;
    generate
        for (i = 0; i < NC; i++) begin : g_onehot
            assign grant_d[i] = hit && (pick == ID_W'(i));
        end
    endgenerate

    // Register grant vector and index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant    <= '0;
            grant_id <= '0;
        end else begin
            grant    <= grant_d;
            grant_id <= hit ? pick : '0;
        end
    end

    // R12: at most one grant, index agrees with it
    p_onehot_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && ((grant == '0) ? (grant_id == '0) : grant[grant_id]));

    // R9: only an eligible core is ever granted
    p_eligible_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((grant & ~$past(elig)) == '0));

    // R6: grant stays in the slot's pair or goes to that slot's moocher
    p_isolation_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (grant == '0) || (grant_id[PW-1:0] == $past(s1_pair)) ||
                 ($past(s1_mooch_vld) && grant_id == $past(s1_mooch_id)));

    // R3: an upper core in lend mode is granted only as a moocher
    p_lend_upper_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> !((grant != '0) && grant_id[ID_W-1] &&
                   ($past(s1_mode) == PM_LEND) &&
                   !($past(s1_mooch_vld) && grant_id == $past(s1_mooch_id))));

endmodule

// File: rtl/hub_pair_arbiter.sv
// Top of the paired-core hub slot arbiter: counter and config latch, a
// one-clock-ahead pair decode, and the registered grant stage.
// Assumes NUM_PAIRS is a power of two; core i pairs with core i+NUM_PAIRS.
module hub_pair_arbiter #(
    parameter int NUM_PAIRS = 8,
    parameter int ID_W      = $clog2(2 * NUM_PAIRS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [2*NUM_PAIRS-1:0] req,
    input  logic [2*NUM_PAIRS-1:0] run,
    input  logic [2*NUM_PAIRS-1:0] pair_mode,
    input  logic [1:0]             mooch_sel,
    input  logic [ID_W-1:0]        mooch_even_id,
    input  logic [ID_W-1:0]        mooch_odd_id,
    output logic [2*NUM_PAIRS-1:0] grant,
    output logic [ID_W-1:0]        grant_id
);
    logic [ID_W-1:0]        slot_cnt;
    logic [2*NUM_PAIRS-1:0] act_mode;
    logic [1:0]             act_mooch;
    logic [ID_W-1:0]        act_even_id;
    logic [ID_W-1:0]        act_odd_id;
    logic                   s1_vld;
    logic [ID_W-2:0]        s1_pair;
    logic [1:0]             s1_mode;
    logic [ID_W-1:0]        s1_prim;
    logic                   s1_sec_vld;
    logic [ID_W-1:0]        s1_sec;
    logic                   s1_mooch_vld;
    logic [ID_W-1:0]        s1_mooch_id;
    logic [2*NUM_PAIRS-1:0] elig;

    assign elig = req & run;

    hub_slot_sequencer #(.NUM_PAIRS(NUM_PAIRS), .ID_W(ID_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_mode    (pair_mode),
        .cfg_mooch   (mooch_sel),
        .cfg_even_id (mooch_even_id),
        .cfg_odd_id  (mooch_odd_id),
        .slot_cnt    (slot_cnt),
        .act_mode    (act_mode),
        .act_mooch   (act_mooch),
        .act_even_id (act_even_id),
        .act_odd_id  (act_odd_id)
    );

    hub_pair_decode #(.NUM_PAIRS(NUM_PAIRS), .ID_W(ID_W)) u_dec (
        .clk          (clk),
        .rst_n        (rst_n),
        .slot_cnt     (slot_cnt),
        .act_mode     (act_mode),
        .act_mooch    (act_mooch),
        .act_even_id  (act_even_id),
        .act_odd_id   (act_odd_id),
        .s1_vld       (s1_vld),
        .s1_pair      (s1_pair),
        .s1_mode      (s1_mode),
        .s1_prim      (s1_prim),
        .s1_sec_vld   (s1_sec_vld),
        .s1_sec       (s1_sec),
        .s1_mooch_vld (s1_mooch_vld),
        .s1_mooch_id  (s1_mooch_id)
    );

    hub_grant_resolve #(.NUM_PAIRS(NUM_PAIRS), .ID_W(ID_W)) u_res (
        .clk          (clk),
        .rst_n        (rst_n),
        .elig         (elig),
        .s1_vld       (s1_vld),
        .s1_pair      (s1_pair),
        .s1_mode      (s1_mode),
        .s1_prim      (s1_prim),
        .s1_sec_vld   (s1_sec_vld),
        .s1_sec       (s1_sec),
        .s1_mooch_vld (s1_mooch_vld),
        .s1_mooch_id  (s1_mooch_id),
        .grant        (grant),
        .grant_id     (grant_id)
    );

endmodule

// File: tb/hub_pair_arbiter_bench.sv
// Bench: behavioural slot model compared against the grant on every clock.
module hub_pair_arbiter_bench;
    localparam int NP = 8;
    localparam int NC = 16;

    typedef struct packed {
        logic [15:0] modes;
        logic [1:0]  ms;
        logic [3:0]  ev;
        logic [3:0]  od;
    } cfg_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] req = '0;
    logic [15:0] run = '1;
    logic [15:0] pair_mode = '0;
    logic [1:0]  mooch_sel = 2'b00;
    logic [3:0]  mooch_even_id = '0;
    logic [3:0]  mooch_odd_id = '0;
    logic [15:0] grant;
    logic [3:0]  grant_id;

    int    checks = 0;
    int    errors = 0;
    int    n_edge = 0;
    int    exp_id = -1;
    int    cycles = 0;
    bit    chk_en = 1'b0;
    bit    done = 1'b0;
    string tag = "R1";
    cfg_t  act_cfg = '0;
    cfg_t  pend_cfg = '0;

    hub_pair_arbiter u_hub_pair_arbiter (
        .clk(clk), .rst_n(rst_n), .req(req), .run(run),
        .pair_mode(pair_mode), .mooch_sel(mooch_sel),
        .mooch_even_id(mooch_even_id), .mooch_odd_id(mooch_odd_id),
        .grant(grant), .grant_id(grant_id)
    );

    always #5 clk = ~clk;

    // Claim order for slot s: owner-side candidate, partner, moocher.
    function automatic int pick(int s, cfg_t c, logic [15:0] e);
        int pr, m;
        int cand[3];
        pr = s % NP;
        m  = int'(c.modes[2*pr +: 2]);
        cand = '{-1, -1, -1};
        case (m)
            0: cand[0] = s;
            1: cand[0] = pr;
            2: begin cand[0] = pr; cand[1] = pr + NP; end
            default: begin cand[0] = s; cand[1] = (s < NP) ? s + NP : s - NP; end
        endcase
        if (c.ms == 2'b01)      cand[2] = int'(c.ev);
        else if (c.ms == 2'b10) cand[2] = (s % 2 == 1) ? int'(c.od) : int'(c.ev);
        for (int k = 0; k < 3; k++)
            if (cand[k] >= 0 && e[cand[k]]) return cand[k];
        return -1;
    endfunction

    // Reference: track rotation phase and the config in force per slot.
    always @(posedge clk) begin
        if (!rst_n) begin
            n_edge   = 0;
            exp_id   = -1;
            act_cfg  = '0;
            pend_cfg = '0;
        end else begin
            exp_id   = (n_edge >= 1) ? pick((n_edge - 1) % NC, pend_cfg, req & run) : -1;
            pend_cfg = act_cfg;
            if (n_edge % NC == NC - 1)
                act_cfg = {pair_mode, mooch_sel, mooch_even_id, mooch_odd_id};
            n_edge++;
        end
    end

    // Compare away from the active edge.
    always @(negedge clk) begin
        if (chk_en) begin
            logic [15:0] eg;
            logic [3:0]  ei;
            eg = (exp_id < 0) ? 16'h0 : (16'h1 << exp_id);
            ei = (exp_id < 0) ? 4'h0 : 4'(exp_id);
            checks++;
            if (grant !== eg) begin
                errors++;
                $display("FAIL %s slot %0d grant actual %h expected %h", tag, (n_edge - 2) % NC, grant, eg);
            end
            checks++;
            if (grant_id !== ei) begin
                errors++;
                $display("FAIL R12 (phase %s) grant_id actual %0d expected %0d", tag, grant_id, ei);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    task automatic drive_req(int kind);
        case (kind)
            0: req = '1;
            1: req = 16'($urandom);
            2: req = 16'($urandom) & 16'($urandom) & 16'($urandom);
            default: req = '0;
        endcase
    endtask

    task automatic phase(string t, int ncyc, int kind, bit rand_run);
        tag = t;
        for (int c = 0; c < ncyc; c++) begin
            @(negedge clk);
            drive_req(kind);
            if (rand_run) run = 16'($urandom) | 16'($urandom);
        end
    endtask

    task automatic set_cfg(logic [15:0] m, logic [1:0] s, logic [3:0] e, logic [3:0] o);
        pair_mode = m; mooch_sel = s; mooch_even_id = e; mooch_odd_id = o;
    endtask

    initial begin
        // R1: reset state, with non-default config already present
        set_cfg(16'h5555, 2'b01, 4'd5, 4'd6);
        req = '1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        tag = "R1";
        chk_en = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        // R1: first rotation is unpaired without mooching; R10 latch at wrap
        phase("R1", 17, 0, 1'b0);
        phase("R3", 64, 1, 1'b0);
        phase("R3", 20, 0, 1'b0);
        // R2: plain rotation
        set_cfg(16'h0000, 2'b00, 4'd0, 4'd0);
        phase("R2", 40, 0, 1'b0);
        phase("R2", 48, 1, 1'b0);
        // R4: lead mode on all pairs
        set_cfg(16'hAAAA, 2'b00, 4'd0, 4'd0);
        phase("R4", 80, 1, 1'b0);
        // R5: own-first mode on all pairs
        set_cfg(16'hFFFF, 2'b00, 4'd0, 4'd0);
        phase("R5", 80, 1, 1'b0);
        // R6: mixed modes, pairs must not disturb each other
        for (int r = 0; r < 6; r++) begin
            set_cfg(16'($urandom), 2'b00, 4'd0, 4'd0);
            phase("R6", 32, 1, 1'b0);
        end
        // R7: single moocher
        set_cfg(16'h0000, 2'b01, 4'd9, 4'd2);
        phase("R7", 48, 2, 1'b0);
        set_cfg(16'h1B1B, 2'b01, 4'd12, 4'd0);
        phase("R7", 48, 2, 1'b0);
        // R8: parity split moochers, and select 11 as off
        set_cfg(16'h0000, 2'b10, 4'd4, 4'd11);
        phase("R8", 48, 2, 1'b0);
        set_cfg(16'hE4E4, 2'b10, 4'd15, 4'd0);
        phase("R8", 48, 2, 1'b0);
        set_cfg(16'h0000, 2'b11, 4'd4, 4'd11);
        phase("R8", 40, 2, 1'b0);
        // R9: random running flags
        for (int r = 0; r < 4; r++) begin
            set_cfg(16'($urandom), 2'($urandom), 4'($urandom), 4'($urandom));
            phase("R9", 32, 1, 1'b1);
        end
        run = '1;
        // R10: config changes off the rotation boundary
        for (int r = 0; r < 10; r++) begin
            set_cfg(16'($urandom), 2'($urandom), 4'($urandom), 4'($urandom));
            phase("R10", 7, (r % 2 == 0) ? 0 : 1, 1'b0);
        end
        // R11: nobody eligible, then sparse requests
        set_cfg(16'hFFFF, 2'b01, 4'd3, 4'd3);
        phase("R11", 40, 3, 1'b0);
        phase("R11", 40, 2, 1'b0);
        set_cfg(16'h5A5A, 2'b10, 4'd1, 4'd14);
        phase("R11", 40, 2, 1'b1);
        run = '1;
        @(negedge clk);
        chk_en = 1'b0;
        finish_run();
    end

endmodule